// File: doc/BRIEF.md
# Peripheral Clock Gate Controller

This block holds the on/off state of a bank of peripheral clocks and drives one gate-enable line per clock. The clocks are split into groups of 32. Software reaches each group through four word registers on a simple single-port register bus:

- an enable register, where a write of 1 to a bit turns that clock's request on;
- a disable register, where a write of 1 to a bit turns that clock's request off;
- a request readback register, which shows the requested state;
- a status register, which shows the state of the gate.

A clock gate does not switch the moment it is asked to. The status bit of each clock follows its request only after a fixed settling delay. Driver code writes the enable or disable register and then polls the status register until it agrees with the request. The gate-enable output of each clock equals its status bit, so the downstream gating cell only switches once the delay has run out.

The group-0 registers sit at byte offsets 0x24 (enable), 0x28 (disable), 0x2C (request) and 0x30 (status). Each further group sits 0x10 higher, so group 1 uses 0x34, 0x38, 0x3C and 0x40.

Top module: `periph_clkgate`

## Requirements
- R1: After a synchronous reset every request bit, every status bit and every `gate_en` line equals the `RESET_ON` parameter (default 1, all clocks running).
- R2: A write to a group's enable register (0x24 group 0, 0x34 group 1) sets each request bit whose data bit is 1. Bits written as 0 keep their value. The request register (0x2C, 0x3C) reads back the requested state.
- R3: A write to a group's disable register (0x28 group 0, 0x38 group 1) clears each request bit whose data bit is 1. Bits written as 0 keep their value.
- R4: Clock i belongs to group i/32 and uses bit i mod 32 of that group's registers. A write to one group never alters another group.
- R5: A status bit takes the value of its request bit on the SETTLE-th rising edge after the edge that changed the request (default SETTLE = 4), provided the request is held for that long.
- R6: If a request bit returns to its status value before the delay has run out, the status bit does not change. A later change starts a full new delay.
- R7: The status registers (0x30, 0x40) are read-only. A write to them changes no request or status bit.
- R8: A read of an enable or disable address, or of any unmapped offset, returns zero. A write to an unmapped offset changes nothing.
- R9: `gate_en[i]` equals the status bit of clock i, as read back from the status register.
- R10: `bus_rdata` is loaded on the rising edge that ends a read access and holds its value through cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | GROUP_W (32) | Write data |
| bus_rdata | output | GROUP_W (32) | Read data, registered |
| gate_en | output | NUM_GROUPS*GROUP_W (64) | Per-clock gate enable, equal to status |

## Verification
These delays are counted from the rising edge that takes a write:

- The request bit changes on that same edge.
- The status bit and `gate_en` follow exactly SETTLE edges later.
- Read data appears one edge after the read access.

The bench drives each access just after a falling edge and runs a cycle-accurate reference of request, status and per-bit age. It then compares `gate_en` with that reference on every falling edge, and compares read data on the falling edge after the read. Off-by-one errors in the delay therefore show up in the first cycle where they differ. Directed sequences cover the following cases:

- a delay that is cancelled partway;
- writes to read-only status registers;
- accesses to unmapped addresses.

// File: rtl/pcg_pkg.sv
// Package: pcg_pkg
// Shared register-kind encoding and address map constants for the clock
// gate controller. Assumes byte addressing with 32-bit word registers.
package pcg_pkg;

    // Kind of register hit by a bus address
    typedef enum logic [2:0] {
        ACC_NONE = 3'd0,
        ACC_SET  = 3'd1,
        ACC_CLR  = 3'd2,
        ACC_REQ  = 3'd3,
        ACC_STAT = 3'd4
    } acc_kind_e;

    // Byte offset of group 0's enable register
    localparam int unsigned FIRST_OFS    = 32'h24;
    // Byte distance between consecutive groups
    localparam int unsigned GROUP_STRIDE = 32'h10;
    // Byte offsets of each register within a group
    localparam int unsigned OFS_SET      = 32'h0;
    localparam int unsigned OFS_CLR      = 32'h4;
    localparam int unsigned OFS_REQ      = 32'h8;
    localparam int unsigned OFS_STAT     = 32'hC;

endpackage

// File: rtl/pcg_decode.sv
// Module: pcg_decode
// Maps a bus byte address onto a register kind and a group number.
// Purely combinational. Addresses outside the map give ACC_NONE.
// Assumes NUM_GROUPS groups laid out at a fixed stride from FIRST_OFS.
module pcg_decode
    import pcg_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int ADDR_W     = 8,
    localparam int GSEL_W    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [GSEL_W-1:0] grp
);

    // Compare the address against each group's four register offsets
    always_comb begin
        kind = ACC_NONE;
        grp  = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (addr == ADDR_W'(FIRST_OFS + g * GROUP_STRIDE + OFS_SET)) begin
                kind = ACC_SET;
                grp  = GSEL_W'(g);
            end else if (addr == ADDR_W'(FIRST_OFS + g * GROUP_STRIDE + OFS_CLR)) begin
                kind = ACC_CLR;
                grp  = GSEL_W'(g);
            end else if (addr == ADDR_W'(FIRST_OFS + g * GROUP_STRIDE + OFS_REQ)) begin
                kind = ACC_REQ;
                grp  = GSEL_W'(g);
            end else if (addr == ADDR_W'(FIRST_OFS + g * GROUP_STRIDE + OFS_STAT)) begin
                kind = ACC_STAT;
                grp  = GSEL_W'(g);
            end
        end
    end

endmodule

// File: rtl/pcg_req_bank.sv
// Module: pcg_req_bank
// Holds one group's request bits. A bit set in set_mask turns the request
// on; a bit set in clr_mask turns it off. The clear takes priority if both
// are set. Assumes the masks are zero in cycles with no matching write.
module pcg_req_bank #(
    parameter int   W        = 32,
    parameter logic RESET_ON = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] req
);

    // Request register: reset to RESET_ON, then set/clear by mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= {W{RESET_ON}};
        end else begin
            req <= (req | set_mask) & ~clr_mask;
        end
    end

endmodule

// File: rtl/pcg_settle.sv
// Module: pcg_settle
// Per-bit settling tracker. Each status bit follows its request bit after
// SETTLE consecutive edges of disagreement. Agreement resets that bit's
// counter, so a request that reverts cancels the pending change.
// Assumes SETTLE >= 1.
module pcg_settle #(
    parameter int   W        = 32,
    parameter int   SETTLE   = 4,
    parameter logic RESET_ON = 1'b1,
    localparam int  CW       = (SETTLE > 1) ? $clog2(SETTLE + 1) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    output logic [W-1:0] status
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [CW-1:0] cnt;

        // Count edges of disagreement; copy request once the delay expires
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt       <= '0;
                status[b] <= RESET_ON;
            end else if (req[b] != status[b]) begin
                if (cnt == CW'(SETTLE - 1)) begin
                    cnt       <= '0;
                    status[b] <= req[b];
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/periph_clkgate.sv
// Module: periph_clkgate
// Top of the peripheral clock gate controller. It decodes single-port
// register accesses, keeps per-group request banks, tracks status through
// the settling delay, and drives one gate enable per clock from status.
// Assumes one access per cycle; read data is registered.
module periph_clkgate
    import pcg_pkg::*;
#(
    parameter int   NUM_GROUPS = 2,
    parameter int   GROUP_W    = 32,
    parameter int   ADDR_W     = 8,
    parameter int   SETTLE     = 4,
    parameter logic RESET_ON   = 1'b1,
    localparam int  TOTAL      = NUM_GROUPS * GROUP_W,
    localparam int  GSEL_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [GROUP_W-1:0] bus_wdata,
    output logic [GROUP_W-1:0] bus_rdata,
    output logic [TOTAL-1:0]   gate_en
);

    acc_kind_e          kind;
    logic [GSEL_W-1:0]  grp;
    logic [TOTAL-1:0]   req_q;
    logic [TOTAL-1:0]   stat_q;
    logic [GROUP_W-1:0] rd_next;
    logic               wr_hit;

    pcg_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W)
    ) u_decode (
        .addr (bus_addr),
        .kind (kind),
        .grp  (grp)
    );

    assign wr_hit = bus_valid && bus_write;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [GROUP_W-1:0] set_m;
        logic [GROUP_W-1:0] clr_m;

        // Steer write data into this group's set or clear mask
        always_comb begin
            set_m = '0;
            clr_m = '0;
            if (wr_hit && (grp == GSEL_W'(g))) begin
                if (kind == ACC_SET) set_m = bus_wdata;
                if (kind == ACC_CLR) clr_m = bus_wdata;
            end
        end

        pcg_req_bank #(
            .W        (GROUP_W),
            .RESET_ON (RESET_ON)
        ) u_req (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_m),
            .clr_mask (clr_m),
            .req      (req_q[g*GROUP_W +: GROUP_W])
        );

        pcg_settle #(
            .W        (GROUP_W),
            .SETTLE   (SETTLE),
            .RESET_ON (RESET_ON)
        ) u_settle (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_q[g*GROUP_W +: GROUP_W]),
            .status (stat_q[g*GROUP_W +: GROUP_W])
        );
    end

    // Select read data; enable, disable and unmapped addresses read zero
    always_comb begin
        rd_next = '0;
        case (kind)
            ACC_REQ:  rd_next = req_q[int'(grp)*GROUP_W +: GROUP_W];
            ACC_STAT: rd_next = stat_q[int'(grp)*GROUP_W +: GROUP_W];
            default:  rd_next = '0;
        endcase
    end

    // Register read data at the end of each read access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_valid && !bus_write) begin
            bus_rdata <= rd_next;
        end
    end

    assign gate_en = stat_q;

endmodule

// File: rtl/pcg_checker.sv
// Module: pcg_checker
// Temporal checks on the clock gate controller, bound to periph_clkgate.
// Assumes reset is held low for at least three cycles at start.
module pcg_checker #(
    parameter int   NUM_GROUPS = 2,
    parameter int   GROUP_W    = 32,
    parameter int   ADDR_W     = 8,
    parameter int   SETTLE     = 4,
    parameter logic RESET_ON   = 1'b1,
    localparam int  TOTAL      = NUM_GROUPS * GROUP_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [GROUP_W-1:0] bus_rdata,
    input logic [TOTAL-1:0]   gate_en,
    input logic [TOTAL-1:0]   req_q
);

    logic zero_addr;

    // Flag addresses whose reads must return zero (enable, disable, unmapped)
    always_comb begin
        zero_addr = 1'b1;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (bus_addr == ADDR_W'(32'h2C + g * 32'h10) ||
                bus_addr == ADDR_W'(32'h30 + g * 32'h10))
                zero_addr = 1'b0;
        end
    end

    p_reset_value_r1: assert property (@(posedge clk)
        !rst_n |=> (gate_en == {TOTAL{RESET_ON}}));

    p_req_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q != $past(req_q)) |-> $past(bus_valid && bus_write));

    p_status_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_en ^ $past(gate_en)) & (gate_en ^ $past(req_q))) == '0);

    if (SETTLE >= 2) begin : g_hold
        p_no_fast_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ((gate_en ^ $past(gate_en)) & ($past(req_q) ^ $past(req_q, 2))) == '0);
    end

    p_zero_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && zero_addr) |=> (bus_rdata == '0));

endmodule

bind periph_clkgate pcg_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W),
    .ADDR_W     (ADDR_W),
    .SETTLE     (SETTLE),
    .RESET_ON   (RESET_ON)
) u_pcg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .gate_en   (gate_en),
    .req_q     (req_q)
);

// File: tb/tb_periph_clkgate.sv
// Bench for periph_clkgate: directed corner cases plus seeded random
// accesses, compared against a cycle-level reference held in the bench.
module tb_periph_clkgate;

    localparam int SETTLE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] gate_en;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [63:0] m_req;
    logic [63:0] m_stat;
    int          m_age [64];
    logic [31:0] last_rd;

    periph_clkgate #(.SETTLE(SETTLE)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gate_en   (gate_en)
    );

    always #2 clk = ~clk;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h2C:   return m_req[31:0];
            8'h3C:   return m_req[63:32];
            8'h30:   return m_stat[31:0];
            8'h40:   return m_stat[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [7:0] a);
        if (a == 8'h2C || a == 8'h3C) return "R2";
        if (a == 8'h30 || a == 8'h40) return "R9";
        return "R8";
    endfunction

    // One bus cycle: drive after a falling edge, update the reference at the
    // rising edge, compare outputs at the next falling edge.
    task automatic step(input logic v, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
        logic [31:0] e;
        logic        rd;
        bus_valid = v;
        bus_write = w;
        bus_addr  = a;
        bus_wdata = d;
        rd = v && !w;
        e  = exp_rd(a);
        @(posedge clk);
        for (int b = 0; b < 64; b++) begin
            if (m_req[b] != m_stat[b]) begin
                m_age[b]++;
                if (m_age[b] == SETTLE) begin
                    m_stat[b] = m_req[b];
                    m_age[b]  = 0;
                end
            end else begin
                m_age[b] = 0;
            end
        end
        if (v && w) begin
            case (a)
                8'h24: m_req[31:0]  = m_req[31:0] | d;
                8'h28: m_req[31:0]  = m_req[31:0] & ~d;
                8'h34: m_req[63:32] = m_req[63:32] | d;
                8'h38: m_req[63:32] = m_req[63:32] & ~d;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
        chk("R5 gate_en timing", gate_en, m_stat);
        if (rd) begin
            chk(tag == "" ? rd_tag(a) : tag, {32'h0, bus_rdata}, {32'h0, e});
            last_rd = e;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 32'h0, "");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_req  = '1;
        m_stat = '1;
        for (int b = 0; b < 64; b++) m_age[b] = 0;
        last_rd = '0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 gate_en after reset", gate_en, {64{1'b1}});
        step(1'b1, 1'b0, 8'h2C, 32'h0, "R1");
        step(1'b1, 1'b0, 8'h40, 32'h0, "R1");

        // R3 + R5: disable four clocks in group 0, watch status settle
        step(1'b1, 1'b1, 8'h28, 32'h0000_00F0, "");
        step(1'b1, 1'b0, 8'h2C, 32'h0, "R3");
        chk("R5 status still high mid-delay", {63'h0, gate_en[4]}, 64'h1);
        idle(SETTLE);
        chk("R5 status low after delay", {56'h0, gate_en[7:0]}, 64'h0F);

        // R2: enable bits back, zero bits ignored
        step(1'b1, 1'b1, 8'h24, 32'h0000_0030, "");
        step(1'b1, 1'b0, 8'h2C, 32'h0, "R2");
        idle(SETTLE);
        step(1'b1, 1'b0, 8'h30, 32'h0, "R9");

        // R4: clock 40 is group 1, bit 8; group 0 untouched
        step(1'b1, 1'b1, 8'h38, 32'h0000_0100, "");
        step(1'b1, 1'b0, 8'h3C, 32'h0, "R4");
        step(1'b1, 1'b0, 8'h2C, 32'h0, "R4");
        idle(SETTLE);
        chk("R4 gate 40 off", {63'h0, gate_en[40]}, 64'h0);

        // R6: revert a request before the delay ends, then restart
        step(1'b1, 1'b1, 8'h34, 32'h0000_0100, "");
        idle(1);
        step(1'b1, 1'b1, 8'h38, 32'h0000_0100, "");
        idle(SETTLE + 2);
        chk("R6 cancelled change", {63'h0, gate_en[40]}, 64'h0);
        step(1'b1, 1'b1, 8'h34, 32'h0000_0100, "");
        idle(SETTLE - 2);
        chk("R6 restarted delay not done", {63'h0, gate_en[40]}, 64'h0);
        idle(2);
        chk("R6 restarted delay done", {63'h0, gate_en[40]}, 64'h1);

        // R7: status registers ignore writes
        step(1'b1, 1'b1, 8'h28, 32'h0000_000F, "");
        idle(SETTLE);
        step(1'b1, 1'b1, 8'h30, 32'hFFFF_FFFF, "");
        step(1'b1, 1'b1, 8'h40, 32'h0000_0000, "");
        idle(SETTLE);
        step(1'b1, 1'b0, 8'h30, 32'h0, "R7");
        step(1'b1, 1'b0, 8'h40, 32'h0, "R7");

        // R8: zero reads and ignored unmapped writes
        step(1'b1, 1'b0, 8'h24, 32'h0, "R8");
        step(1'b1, 1'b0, 8'h38, 32'h0, "R8");
        step(1'b1, 1'b1, 8'h00, 32'hFFFF_FFFF, "");
        step(1'b1, 1'b1, 8'h44, 32'hFFFF_FFFF, "");
        step(1'b1, 1'b0, 8'h44, 32'h0, "R8");
        step(1'b1, 1'b0, 8'h2C, 32'h0, "R8");

        // R10: read data holds through non-read cycles
        step(1'b1, 1'b0, 8'h2C, 32'h0, "R10");
        step(1'b1, 1'b1, 8'h34, 32'h0000_00FF, "");
        idle(2);
        chk("R10 rdata held", {32'h0, bus_rdata}, {32'h0, last_rd});

        // Seeded random traffic with sparse data patterns
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        v;
            logic        w;
            a = 8'h20 + 8'(4 * ($urandom % 10));
            d = $urandom & $urandom;
            v = ($urandom % 4) != 0;
            w = $urandom % 2;
            step(v, w, a, d, "");
        end
        idle(SETTLE + 1);
        step(1'b1, 1'b0, 8'h30, 32'h0, "R9");
        step(1'b1, 1'b0, 8'h40, 32'h0, "R9");

        finish_run();
    end

endmodule